// File: doc/BRIEF.md
# Three-Channel Square-Wave Tone and Mixer Core

This core turns register settings into three 4-bit output levels, one per channel. Each channel divides the system clock first by a fixed prescaler of 16. It then divides the result by its own 12-bit period to make a square wave.

Every channel then combines its square wave with a shared noise bit. Two active-low enables from the mixer register control this. If the combined gate is open, the channel passes either its own fixed 4-bit level or the shared envelope level to a registered output, as chosen by a mode bit in the amplitude register. If the gate is closed, the output is 0. Noise generation, the envelope counter and the analog converters sit outside the core and connect through plain ports.

Top module: `tri_tone_mixer`

## Requirements
- R1: The prescaler issues one advance strobe every 16 clock cycles, and a tone output can change only on a cycle that carries that strobe.
- R2: A channel with period P (1 to 4095) inverts its tone every P strobes. Its output therefore stays for 16*P clock cycles in each half of the square wave.
- R3: A channel's period is {coarse[3:0], fine[7:0]}. Coarse bits 7:4 have no effect.
- R4: A period value of 0 behaves as a period of 1, which gives a half wave of 16 clock cycles.
- R5: In the mixer control byte, bits 0, 1 and 2 disable the tone of channels A, B and C. Bits 3, 4 and 5 disable the noise of channels A, B and C. A 1 disables and a 0 enables. Bits 7:6 have no effect.
- R6: A channel's gate is (tone OR tone-disable) AND (noise OR noise-disable). While the gate is 0, the channel's level is 0.
- R7: With the gate open, amplitude bit 4 = 1 selects the envelope level. Bit 4 = 0 selects amplitude bits 3:0. Amplitude bits 7:5 have no effect.
- R8: Each level output is registered. A change on the inputs shows at the output after exactly one rising clock edge.
- R9: While reset is held, all levels are 0. After reset, every tone starts low, so a channel with its tone enabled outputs 0 until its first inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fine_a | input | 8 | Channel A period, low byte |
| coarse_a | input | 8 | Channel A period, upper nibble in bits 3:0 |
| fine_b | input | 8 | Channel B period, low byte |
| coarse_b | input | 8 | Channel B period, upper nibble in bits 3:0 |
| fine_c | input | 8 | Channel C period, low byte |
| coarse_c | input | 8 | Channel C period, upper nibble in bits 3:0 |
| mix_ctrl | input | 8 | Active-low tone and noise enables |
| amp_a | input | 8 | Channel A level/mode |
| amp_b | input | 8 | Channel B level/mode |
| amp_c | input | 8 | Channel C level/mode |
| noise_bit | input | 1 | Shared noise bit |
| env_level | input | 4 | Shared envelope level |
| level_a | output | 4 | Channel A output level code |
| level_b | output | 4 | Channel B output level code |
| level_c | output | 4 | Channel C output level code |

## Verification
The tone state is never visible directly. It shows only through the gate, and then only when the tone is enabled and the noise term is held open. The timing stimulus therefore disables noise and enables the tone on all three channels, with full fixed level. It then measures the cycle distance between output transitions, and only after two transitions have passed, so that any partial first half wave is skipped. The three channels carry a period of 3, a period of 0, and a value that uses the coarse nibble with junk in coarse bits 7:4. This covers R2, R3 and R4 in one pass. The low tone state after reset is observed in the first few cycles after release, before the first strobe can arrive.

// File: rtl/tone_mix_pkg.sv
package tone_mix_pkg;
    localparam int NUM_CH   = 3;
    localparam int PER_W    = 12;
    localparam int LVL_W    = 4;
    localparam int REG_W    = 8;
    localparam int PRE_DIV  = 16;

    typedef logic [PER_W-1:0] period_t;
    typedef logic [LVL_W-1:0] level_t;
    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        period_t cnt;
        logic    tone;
    } chan_state_t;

    typedef struct packed {
        level_t [NUM_CH-1:0] lvl;
    } out_state_t;
endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
    parameter int DIV = tone_mix_pkg::PRE_DIV
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_mix_pkg::*;
#(
    parameter int P_W = PER_W,
    parameter int R_W = REG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [R_W-1:0] coarse,
    input  logic [R_W-1:0] fine,
    output logic           tone
);
    localparam int HI_W = P_W - R_W;

    typedef struct packed {
        logic [P_W-1:0] cnt;
        logic           tone;
    } st_t;

    st_t st_d, st_q;
    logic [P_W-1:0] period;
    logic [P_W-1:0] period_eff;
    logic [P_W:0]   cnt_next;

    assign period     = {coarse[HI_W-1:0], fine};
    assign period_eff = (period == '0) ? P_W'(1) : period;
    assign cnt_next   = {1'b0, st_q.cnt} + 1'b1;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (cnt_next >= {1'b0, period_eff}) begin
                st_d.cnt  = '0;
                st_d.tone = ~st_q.tone;
            end else begin
                st_d.cnt  = cnt_next[P_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tone = st_q.tone;
endmodule

// File: rtl/chan_mixer.sv
module chan_mixer #(
    parameter int L_W = tone_mix_pkg::LVL_W,
    parameter int R_W = tone_mix_pkg::REG_W
) (
    input  logic           tone,
    input  logic           noise,
    input  logic           tone_off,
    input  logic           noise_off,
    input  logic [R_W-1:0] amp,
    input  logic [L_W-1:0] env,
    output logic [L_W-1:0] level
);
    localparam int MODE_BIT = L_W;

    logic gate;

    always_comb begin
        gate = (tone | tone_off) & (noise | noise_off);
        if (!gate) begin
            level = '0;
        end else if (amp[MODE_BIT]) begin
            level = env;
        end else begin
            level = amp[L_W-1:0];
        end
    end
endmodule

// File: rtl/tri_tone_mixer.sv
module tri_tone_mixer
    import tone_mix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fine_a,
    input  logic [7:0] coarse_a,
    input  logic [7:0] fine_b,
    input  logic [7:0] coarse_b,
    input  logic [7:0] fine_c,
    input  logic [7:0] coarse_c,
    input  logic [7:0] mix_ctrl,
    input  logic [7:0] amp_a,
    input  logic [7:0] amp_b,
    input  logic [7:0] amp_c,
    input  logic       noise_bit,
    input  logic [3:0] env_level,
    output logic [3:0] level_a,
    output logic [3:0] level_b,
    output logic [3:0] level_c
);
    localparam int NOISE_OFS = NUM_CH;

    logic                tick;
    logic [NUM_CH-1:0]   tone_vec;
    reg_t [NUM_CH-1:0]   coarse_arr;
    reg_t [NUM_CH-1:0]   fine_arr;
    reg_t [NUM_CH-1:0]   amp_arr;
    level_t [NUM_CH-1:0] mix_lvl;
    out_state_t          out_d, out_q;

    assign coarse_arr = {coarse_c, coarse_b, coarse_a};
    assign fine_arr   = {fine_c, fine_b, fine_a};
    assign amp_arr    = {amp_c, amp_b, amp_a};

    tone_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tone_channel #(.P_W(PER_W), .R_W(REG_W)) u_tone (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .coarse (coarse_arr[ch]),
            .fine   (fine_arr[ch]),
            .tone   (tone_vec[ch])
        );

        chan_mixer #(.L_W(LVL_W), .R_W(REG_W)) u_mix (
            .tone      (tone_vec[ch]),
            .noise     (noise_bit),
            .tone_off  (mix_ctrl[ch]),
            .noise_off (mix_ctrl[NOISE_OFS + ch]),
            .amp       (amp_arr[ch]),
            .env       (env_level),
            .level     (mix_lvl[ch])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.lvl = mix_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign level_a = out_q.lvl[0];
    assign level_b = out_q.lvl[1];
    assign level_c = out_q.lvl[2];
endmodule

// File: rtl/tri_tone_mixer_chk.sv
module tri_tone_mixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mix_ctrl,
    input logic [7:0] amp_a,
    input logic       noise_bit,
    input logic [3:0] env_level,
    input logic [3:0] level_a,
    input logic       tick,
    input logic [2:0] tone_vec
);
    // R1: the tone state moves only on a strobe cycle
    assert_tone_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone_vec));

    // R1: strobes never come on back-to-back cycles
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6: closed noise gate forces level 0
    assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!mix_ctrl[3] && !noise_bit)) |-> (level_a == 4'h0));

    // R7: fixed level passes when both terms are disabled
    assert_fixed_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mix_ctrl[0] && mix_ctrl[3] && !amp_a[4]))
            |-> (level_a == $past(amp_a[3:0])));

    // R7: envelope level passes in envelope mode
    assert_env_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mix_ctrl[0] && mix_ctrl[3] && amp_a[4]))
            |-> (level_a == $past(env_level)));
endmodule

bind tri_tone_mixer tri_tone_mixer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mix_ctrl  (mix_ctrl),
    .amp_a     (amp_a),
    .noise_bit (noise_bit),
    .env_level (env_level),
    .level_a   (level_a),
    .tick      (tick),
    .tone_vec  (tone_vec)
);

// File: tb/sim_tri_tone_mixer.sv
`timescale 1ns/1ps
module sim_tri_tone_mixer;
    localparam int CLK_NS = 10;
    localparam int NVEC   = 10;

    // {mix, amp_a, amp_b, amp_c, noise, env, exp_a, exp_b, exp_c}
    localparam logic [48:0] VEC [NVEC] = '{
        {8'h3F, 8'h05, 8'h0A, 8'h0F, 1'b0, 4'h3, 4'h5, 4'hA, 4'hF},
        {8'h3F, 8'h10, 8'h1F, 8'h07, 1'b0, 4'h9, 4'h9, 4'h9, 4'h7},
        {8'h07, 8'h05, 8'h0A, 8'h0F, 1'b0, 4'h3, 4'h0, 4'h0, 4'h0},
        {8'h07, 8'h05, 8'h0A, 8'h0F, 1'b1, 4'h3, 4'h5, 4'hA, 4'hF},
        {8'h17, 8'h05, 8'h0A, 8'h0F, 1'b0, 4'h3, 4'h0, 4'hA, 4'h0},
        {8'h2F, 8'h05, 8'h0A, 8'h0F, 1'b0, 4'h3, 4'h5, 4'h0, 4'hF},
        {8'h3F, 8'hE3, 8'h30, 8'hC0, 1'b0, 4'h6, 4'h3, 4'h6, 4'h0},
        {8'h3F, 8'h10, 8'h10, 8'h10, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0},
        {8'h3F, 8'h10, 8'h10, 8'h10, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF},
        {8'hFF, 8'h04, 8'h08, 8'h0C, 1'b0, 4'h1, 4'h4, 4'h8, 4'hC}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] fine_a, coarse_a, fine_b, coarse_b, fine_c, coarse_c;
    logic [7:0] mix_ctrl, amp_a, amp_b, amp_c;
    logic       noise_bit;
    logic [3:0] env_level;
    logic [3:0] level_a, level_b, level_c;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2) clk = ~clk;

    tri_tone_mixer u0 (
        .clk(clk), .rst_n(rst_n),
        .fine_a(fine_a), .coarse_a(coarse_a),
        .fine_b(fine_b), .coarse_b(coarse_b),
        .fine_c(fine_c), .coarse_c(coarse_c),
        .mix_ctrl(mix_ctrl), .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c),
        .noise_bit(noise_bit), .env_level(env_level),
        .level_a(level_a), .level_b(level_b), .level_c(level_c)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input int ch);
        case (ch)
            0:       return level_a;
            1:       return level_b;
            default: return level_c;
        endcase
    endfunction

    // cycles between the 2nd and 3rd output change of a channel
    task automatic measure(input int ch, output int half);
        logic [3:0] prev;
        int n;
        half = -1;
        prev = pick(ch);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (pick(ch) == prev && n < 20000);
            prev = pick(ch);
            if (k == 2) half = n;
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int half;
        rst_n = 1'b0;
        fine_a = 8'h00; coarse_a = 8'h01;
        fine_b = 8'h00; coarse_b = 8'h01;
        fine_c = 8'h00; coarse_c = 8'h01;
        mix_ctrl = 8'h3E; amp_a = 8'h0F; amp_b = 8'h0F; amp_c = 8'h0F;
        noise_bit = 1'b0; env_level = 4'h0;
        repeat (4) @(negedge clk);
        // R9: levels held at 0 during reset
        check("R9 reset level_a", level_a, 0);
        check("R9 reset level_b", level_b, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: tone enabled on A starts low, B tone disabled shows fixed level
        check("R9 tone low after reset A", level_a, 0);
        check("R6 disabled terms B", level_b, 15);

        // vector table: R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            {mix_ctrl, amp_a, amp_b, amp_c, noise_bit, env_level} = VEC[i][48:12];
            @(negedge clk);
            check($sformatf("R5/R6/R7 vec %0d A", i), level_a, int'(VEC[i][11:8]));
            check($sformatf("R5/R6/R7 vec %0d B", i), level_b, int'(VEC[i][7:4]));
            check($sformatf("R5/R6/R7 vec %0d C", i), level_c, int'(VEC[i][3:0]));
        end

        // R8: one-edge latency
        mix_ctrl = 8'h3F; amp_a = 8'h05;
        @(negedge clk);
        amp_a = 8'h09;
        #1;
        check("R8 holds before edge", level_a, 5);
        @(negedge clk);
        check("R8 updates after one edge", level_a, 9);

        // tone timing: noise off, tone on, full level
        amp_a = 8'h0F; amp_b = 8'h0F; amp_c = 8'h0F;
        coarse_a = 8'hF0; fine_a = 8'h03;   // P=3, junk upper nibble
        coarse_b = 8'h00; fine_b = 8'h00;   // P=0 -> 1
        coarse_c = 8'hF1; fine_c = 8'h00;   // P=0x100, junk upper nibble
        mix_ctrl = 8'h38;
        measure(0, half);
        check("R2/R3 half period A", half, 48);
        measure(1, half);
        check("R4/R1 half period B", half, 16);
        measure(2, half);
        check("R3/R2 half period C", half, 4096);

        summary();
    end
endmodule